// File: doc/BRIEF.md
# Configurable Two-Block LUT Logic Fabric

This block is a small field-programmable logic fabric. Sixteen logic elements are grouped into two blocks of eight. Every element evaluates any Boolean function of two operands through a four-entry truth table. It can hold that result in its own flip-flop and present either the raw table output or the stored value on its external output pin. Each element's operands come through two small selectors. The first can pick a dedicated external pin, the stored value of any element in the same block, or a fixed link from the other block. The second can pick the pin or a same-block stored value. The two blocks are joined only by those fixed links, so one block's last element can drive the other block's first element.

All configuration arrives over a simple write bus of address, data and strobe. A read strobe captures all sixteen element outputs into one word. Two selectors each choose one element output and turn a rising edge on it into a one-cycle pulse: one serves as an interrupt request and the other as a converter start request. Operand feedback inside a block and across the links always uses the stored flip-flop values. No configuration can therefore form a combinational loop.

Top module: `lut_fabric`

## Requirements
- R1: While `rst` is high at a clock edge, every configuration word, block enable, pulse selector, element flip-flop, `rd_data`, `irq_pulse` and `cnv_pulse` returns to zero, so after reset all of them read 0.
- R2: With bit 4 of its configuration word clear, element k drives `pin_out[k]` combinationally with `truth[{b,a}]`, where truth is bits 3:0 of the word, a is operand A and b is operand B.
- R3: With bit 4 set, `pin_out[k]` shows the element's flip-flop, which loads `truth[{b,a}]` at each clock edge where its block is enabled.
- R4: Register 16 bit n enables the flip-flops of block n (block 0 = elements 0–7, block 1 = elements 8–15). While that bit is 0, the block's flip-flops hold, and the other block keeps running.
- R5: Operand A source is selected by bits 6:5: 0 = cross-block link, 1 = the element's own pin `pin_in[k]`, 2 = the flip-flop of same-block element with local index bits 9:7, 3 = constant 0.
- R6: Operand B source is selected by bit 10: 0 = own pin, 1 = the flip-flop of same-block element with local index bits 13:11.
- R7: The link of element 0 is the flip-flop of element 15, and the link of element 8 is the flip-flop of element 7. The link of every other element reads 0.
- R8: Writes with `wr_en` high land at the clock edge. Addresses 0–15 load the configuration word of that element, 16 the block enables (bits 1:0), 17 the interrupt selector (bits 3:0) and 18 the converter selector (bits 3:0). Writes to addresses 19–31 change nothing.
- R9: A clock edge with `rd_en` high loads `rd_data` with `pin_out` as it stood before the edge, bit i holding element i. Otherwise `rd_data` holds.
- R10: `irq_pulse` is high for exactly the one cycle after a clock edge at which the element chosen by register 17 shows 1 on its output, having shown 0 at the previous edge.
- R11: `cnv_pulse` behaves the same way for the element chosen by register 18, independently of `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 14 | Register write data |
| rd_en | input | 1 | Capture element outputs into `rd_data` |
| pin_in | input | 16 | External input, one per element |
| pin_out | output | 16 | External output, one per element |
| rd_data | output | 16 | Captured element outputs |
| irq_pulse | output | 1 | Rising-edge pulse of the interrupt-selected output |
| cnv_pulse | output | 1 | Rising-edge pulse of the converter-selected output |

## Verification
The bench sweeps all sixteen truth tables against all four operand pairs. A swapped table index would show up there as the wrong output for the mixed pairs 01 and 10. It drives the two cross links in both directions and checks that an element with no link reads 0. A link wired to the wrong block, or to the combinational value, would lag or echo the wrong pin. It writes to an address whose low four bits alias an element, which catches a truncated address decode. It disables one block while the other runs, which shows an enable that is shared or inverted. It also raises the interrupt-selected and converter-selected outputs separately and holds them high. A level-sensitive or cross-wired pulse path would then stay high or fire on the wrong output.

// File: rtl/lut_fabric_pkg.sv
package lut_fabric_pkg;

    localparam int BLK_CNT       = 2;
    localparam int ELEMS_PER_BLK = 8;
    localparam int ELEM_CNT      = BLK_CNT * ELEMS_PER_BLK;
    localparam int ELEM_IDX_W    = $clog2(ELEM_CNT);
    localparam int LOC_IDX_W     = $clog2(ELEMS_PER_BLK);
    localparam int TRUTH_W       = 4;
    localparam int REG_ADDR_W    = 5;

    typedef enum logic [1:0] {
        A_FROM_LINK = 2'd0,
        A_FROM_PIN  = 2'd1,
        A_FROM_ELEM = 2'd2,
        A_FROM_ZERO = 2'd3
    } a_src_e;

    typedef enum logic {
        B_FROM_PIN  = 1'b0,
        B_FROM_ELEM = 1'b1
    } b_src_e;

    // Packed MSB first: truth table lands in bits 3:0.
    typedef struct packed {
        logic [LOC_IDX_W-1:0] b_idx;
        b_src_e               b_src;
        logic [LOC_IDX_W-1:0] a_idx;
        a_src_e               a_src;
        logic                 use_reg;
        logic [TRUTH_W-1:0]   truth;
    } elem_cfg_t;

    localparam int CFG_W = $bits(elem_cfg_t);

    localparam logic [REG_ADDR_W-1:0] ADDR_BLK_CE  = REG_ADDR_W'(ELEM_CNT);
    localparam logic [REG_ADDR_W-1:0] ADDR_IRQ_SEL = REG_ADDR_W'(ELEM_CNT + 1);
    localparam logic [REG_ADDR_W-1:0] ADDR_CNV_SEL = REG_ADDR_W'(ELEM_CNT + 2);

    function automatic logic lut_eval(logic [TRUTH_W-1:0] t, logic a, logic b);
        return t[{b, a}];
    endfunction

endpackage

// File: rtl/lut_cfg_regs.sv
module lut_cfg_regs
    import lut_fabric_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [REG_ADDR_W-1:0]                wr_addr,
    input  logic [CFG_W-1:0]                     wr_data,
    output elem_cfg_t [ELEM_CNT-1:0]             cfg,
    output logic [BLK_CNT-1:0]                   blk_ce,
    output logic [ELEM_IDX_W-1:0]                irq_sel,
    output logic [ELEM_IDX_W-1:0]                cnv_sel
);

    for (genvar i = 0; i < ELEM_CNT; i++) begin : g_cfg
        logic hit;
        assign hit = wr_en && (wr_addr == REG_ADDR_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (hit) begin
                cfg[i] <= elem_cfg_t'(wr_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_ce  <= '0;
            irq_sel <= '0;
            cnv_sel <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_BLK_CE:  blk_ce  <= wr_data[BLK_CNT-1:0];
                ADDR_IRQ_SEL: irq_sel <= wr_data[ELEM_IDX_W-1:0];
                ADDR_CNV_SEL: cnv_sel <= wr_data[ELEM_IDX_W-1:0];
                default: ;
            endcase
        end
    end

    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_CNV_SEL) |=> ($stable(blk_ce) && $stable(irq_sel) && $stable(cnv_sel) && $stable(cfg))); // R8

endmodule

// File: rtl/lut_element.sv
module lut_element
    import lut_fabric_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce,
    input  elem_cfg_t                cfg,
    input  logic                     pin,
    input  logic                     link,
    input  logic [ELEMS_PER_BLK-1:0] peer_q,
    output logic                     q,
    output logic                     y
);

    logic opnd_a;
    logic opnd_b;
    logic lut_v;

    always_comb begin
        case (cfg.a_src)
            A_FROM_LINK: opnd_a = link;
            A_FROM_PIN:  opnd_a = pin;
            A_FROM_ELEM: opnd_a = peer_q[cfg.a_idx];
            default:     opnd_a = 1'b0;
        endcase
    end

    assign opnd_b = (cfg.b_src == B_FROM_ELEM) ? peer_q[cfg.b_idx] : pin;
    assign lut_v  = lut_eval(cfg.truth, opnd_a, opnd_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (ce) begin
            q <= lut_v;
        end
    end

    assign y = cfg.use_reg ? q : lut_v;

    AST_FF_HOLDS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q)); // R4
    AST_FF_LOADS_LUT: assert property (@(posedge clk) disable iff (rst)
        ce |=> (q == $past(lut_v))); // R3

endmodule

// File: rtl/lut_edge_sel.sv
module lut_edge_sel
    import lut_fabric_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ELEM_CNT-1:0]   elem_y,
    input  logic [ELEM_IDX_W-1:0] irq_sel,
    input  logic [ELEM_IDX_W-1:0] cnv_sel,
    output logic                  irq_pulse,
    output logic                  cnv_pulse
);

    logic [ELEM_CNT-1:0] prev_y;
    logic [ELEM_CNT-1:0] rise;

    // Per-element history keeps a selector change from faking an edge.
    assign rise = elem_y & ~prev_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_y    <= '0;
            irq_pulse <= 1'b0;
            cnv_pulse <= 1'b0;
        end else begin
            prev_y    <= elem_y;
            irq_pulse <= rise[irq_sel];
            cnv_pulse <= rise[cnv_sel];
        end
    end

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R10
    AST_CNV_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cnv_pulse |=> !cnv_pulse); // R11

endmodule

// File: rtl/lut_fabric.sv
module lut_fabric
    import lut_fabric_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]      wr_data,
    input  logic                  rd_en,
    input  logic [ELEM_CNT-1:0]   pin_in,
    output logic [ELEM_CNT-1:0]   pin_out,
    output logic [ELEM_CNT-1:0]   rd_data,
    output logic                  irq_pulse,
    output logic                  cnv_pulse
);

    elem_cfg_t [ELEM_CNT-1:0] cfg;
    logic [BLK_CNT-1:0]       blk_ce;
    logic [ELEM_IDX_W-1:0]    irq_sel;
    logic [ELEM_IDX_W-1:0]    cnv_sel;
    logic [ELEM_CNT-1:0]      elem_q;

    lut_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .blk_ce  (blk_ce),
        .irq_sel (irq_sel),
        .cnv_sel (cnv_sel)
    );

    for (genvar b = 0; b < BLK_CNT; b++) begin : g_blk
        localparam int BASE     = b * ELEMS_PER_BLK;
        localparam int SRC_BLK  = (b + BLK_CNT - 1) % BLK_CNT;
        localparam int LINK_IDX = SRC_BLK * ELEMS_PER_BLK + ELEMS_PER_BLK - 1;

        for (genvar e = 0; e < ELEMS_PER_BLK; e++) begin : g_elem
            logic link_v;
            if (e == 0) begin : g_linked
                assign link_v = elem_q[LINK_IDX];
            end else begin : g_unlinked
                assign link_v = 1'b0;
            end

            lut_element u_elem (
                .clk    (clk),
                .rst    (rst),
                .ce     (blk_ce[b]),
                .cfg    (cfg[BASE+e]),
                .pin    (pin_in[BASE+e]),
                .link   (link_v),
                .peer_q (elem_q[BASE +: ELEMS_PER_BLK]),
                .q      (elem_q[BASE+e]),
                .y      (pin_out[BASE+e])
            );
        end
    end

    lut_edge_sel u_edge (
        .clk       (clk),
        .rst       (rst),
        .elem_y    (pin_out),
        .irq_sel   (irq_sel),
        .cnv_sel   (cnv_sel),
        .irq_pulse (irq_pulse),
        .cnv_pulse (cnv_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= pin_out;
        end
    end

    AST_READ_CAPTURES_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_data == $past(pin_out))); // R9
    AST_READ_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R9

endmodule

// File: tb/lut_fabric_bench.sv
module lut_fabric_bench;

    localparam int A_LINK = 0;
    localparam int A_PIN  = 1;
    localparam int A_ELEM = 2;
    localparam int A_ZERO = 3;
    localparam int B_PIN  = 0;
    localparam int B_ELEM = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] rd_data;
    logic        irq_pulse;
    logic        cnv_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    lut_fabric u_lut_fabric (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse),
        .cnv_pulse (cnv_pulse)
    );

    function automatic logic [13:0] cfgw(int t, int ur, int asrc, int aidx, int bsrc, int bidx);
        return {3'(bidx), 1'(bsrc), 3'(aidx), 2'(asrc), 1'(ur), 4'(t)};
    endfunction

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(int addr, logic [13:0] data);
        wr_en   = 1'b1;
        wr_addr = 5'(addr);
        wr_data = data;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        chk("R1 pin_out", pin_out, 16'h0);
        chk("R1 rd_data", rd_data, 16'h0);
        chk("R1 pulses", {14'h0, irq_pulse, cnv_pulse}, 16'h0);

        wr(16, 14'h3);
        // element 1: registered copy of its pin, feeds operand B of element 3
        wr(1, cfgw(4'b1010, 1, A_PIN, 0, B_PIN, 0));
        for (int t = 0; t < 16; t++) begin
            wr(3, cfgw(t, 0, A_PIN, 0, B_ELEM, 1));
            for (int v = 0; v < 4; v++) begin
                pin_in[3] = v[0];
                pin_in[1] = v[1];
                tick();
                chk("R2/R6 lut sweep", {15'h0, pin_out[3]}, {15'h0, t[v]});
                if (v == 3) begin
                    rd_en = 1'b1;
                    tick();
                    rd_en = 1'b0;
                    chk("R9 readback", rd_data, {12'h0, t[3], 1'b0, 1'b1, 1'b0});
                end
            end
        end

        // R3: registered output lags the pin by one edge
        wr(3, cfgw(4'b1010, 1, A_PIN, 0, B_PIN, 0));
        pin_in[3] = 1'b0;
        tick();
        pin_in[3] = 1'b1;
        #1;
        chk("R3 before edge", {15'h0, pin_out[3]}, 16'h0);
        tick();
        chk("R3 after edge", {15'h0, pin_out[3]}, 16'h1);

        // R4: block 0 disabled, block 1 running
        wr(9, cfgw(4'b1010, 1, A_PIN, 0, B_PIN, 0));
        pin_in[1] = 1'b1;
        pin_in[9] = 1'b0;
        tick();
        wr(16, 14'h2);
        pin_in[1] = 1'b0;
        pin_in[9] = 1'b1;
        tick();
        chk("R4 block0 held", {15'h0, pin_out[1]}, 16'h1);
        chk("R4 block1 runs", {15'h0, pin_out[9]}, 16'h1);
        wr(16, 14'h3);
        tick();
        chk("R4 block0 resumes", {15'h0, pin_out[1]}, 16'h0);

        // R7/R5: cross links and source codes
        wr(15, cfgw(4'b1010, 1, A_PIN, 0, B_PIN, 0));
        wr(7,  cfgw(4'b1010, 1, A_PIN, 0, B_PIN, 0));
        wr(0,  cfgw(4'b1010, 0, A_LINK, 0, B_PIN, 0));
        wr(8,  cfgw(4'b1010, 0, A_LINK, 0, B_PIN, 0));
        wr(2,  cfgw(4'b1010, 0, A_LINK, 0, B_PIN, 0));
        pin_in[15] = 1'b1;
        pin_in[7]  = 1'b0;
        pin_in[2]  = 1'b1;
        tick();
        chk("R7 link 15->0 high", {15'h0, pin_out[0]}, 16'h1);
        chk("R7 link 7->8 low", {15'h0, pin_out[8]}, 16'h0);
        chk("R7 unlinked element", {15'h0, pin_out[2]}, 16'h0);
        pin_in[15] = 1'b0;
        pin_in[7]  = 1'b1;
        tick();
        chk("R7 link 15->0 low", {15'h0, pin_out[0]}, 16'h0);
        chk("R7 link 7->8 high", {15'h0, pin_out[8]}, 16'h1);

        wr(4, cfgw(4'b0100, 0, A_ZERO, 0, B_PIN, 0));
        pin_in[4] = 1'b1;
        tick();
        chk("R5 code 3 gives zero", {15'h0, pin_out[4]}, 16'h1);
        wr(10, cfgw(4'b1010, 0, A_ELEM, 1, B_PIN, 0));
        pin_in[9] = 1'b1;
        tick();
        chk("R5 element source high", {15'h0, pin_out[10]}, 16'h1);
        pin_in[9] = 1'b0;
        tick();
        chk("R5 element source low", {15'h0, pin_out[10]}, 16'h0);

        // R8: unmapped address aliasing element 4 must not land
        wr(20, cfgw(4'b0000, 0, A_PIN, 0, B_PIN, 0));
        tick();
        chk("R8 unmapped write", {15'h0, pin_out[4]}, 16'h1);

        // R10/R11: edge pulses
        wr(5, cfgw(4'b1010, 0, A_PIN, 0, B_PIN, 0));
        wr(6, cfgw(4'b1010, 0, A_PIN, 0, B_PIN, 0));
        wr(17, 14'd5);
        wr(18, 14'd6);
        tick();
        tick();
        chk("R10/R11 idle", {14'h0, irq_pulse, cnv_pulse}, 16'h0);
        pin_in[6] = 1'b1;
        tick();
        chk("R11 pulse on rise", {14'h0, irq_pulse, cnv_pulse}, 16'h1);
        tick();
        chk("R11 one cycle only", {14'h0, irq_pulse, cnv_pulse}, 16'h0);
        pin_in[5] = 1'b1;
        tick();
        chk("R10 pulse on rise", {14'h0, irq_pulse, cnv_pulse}, 16'h2);
        tick();
        chk("R10 one cycle only", {14'h0, irq_pulse, cnv_pulse}, 16'h0);
        pin_in[5] = 1'b0;
        tick();
        tick();
        chk("R10 no pulse on fall", {15'h0, irq_pulse}, 16'h0);

        // R1: reset mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset clears outputs", pin_out, 16'h0);
        chk("R1 reset clears rd_data", rd_data, 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule